// File: doc/BRIEF.md
# Bus Beat Sequencer with Selectable Data Width

This block takes one memory transaction request and turns it into an address tenure and a train of data beats on an external data bus. A request carries a byte address, a byte count of 1 to 8, a burst flag for a full 32-byte line, and a read/write flag. The data bus is 64 bits or 32 bits wide. The width is taken from a strap input at the first clock edge after reset. It then holds until the next reset.

The address and data phases are separate stages. An accepted request first occupies a single address slot, where it runs its address tenure. It moves to the data stage once its tenure has passed without a retry and the data stage is free. A second request can enter the address slot and complete its tenure while the previous transaction is still moving data. That gives an address pipeline one deep.

Each data beat is presented with its address, its byte-lane enables and a last-beat flag. The beat advances only on a slave acknowledge. A retried address tenure produces no data, and the tenure is repeated.

Top module: `beat_seq`

## Requirements
- R1: While reset is asserted, `req_ready`, `at_valid` and `beat_valid` are all low.
- R2: The bus width is the value of `strap_wide` at the first clock edge after reset release, with 1 for 64 bits and 0 for 32 bits. `req_ready` is low until that edge has occurred.
- R3: On a 64-bit bus, a non-burst request of 1 to 8 bytes makes one beat, and a burst makes four beats.
- R4: On a 32-bit bus, a non-burst request of 1 to 4 bytes makes one beat, an 8-byte request makes two beats, and a burst makes eight beats.
- R5: In a multi-beat transfer, the first beat carries the requested address rounded down to the bus width. Each later beat adds the bus width in bytes, and the address wraps inside the aligned span of the whole transfer (32 bytes for a burst, 8 bytes for a two-beat transfer). A single-beat transfer presents the request address unchanged.
- R6: `beat_lanes` bit i enables byte i of the bus. A single beat sets `size` consecutive bits starting at the address offset within the bus width. A multi-beat transfer enables every lane of the bus on every beat. On a 32-bit bus, bits 7:4 are always zero.
- R7: While `beat_valid` is high and `data_ack` is low, the beat address, lanes and last flag hold. The beat advances only in a cycle with `data_ack` high.
- R8: `beat_last` is high on the final beat of each transaction and on no other beat. `beat_write` follows the request's write flag.
- R9: If `addr_retry` is high during an address tenure, no data beat comes from that tenure, and the tenure is repeated in the next cycle with the same address.
- R10: `req_ready` is high only when the address slot is empty. A request's address tenure (`at_valid`) starts in the cycle after it is accepted, even while an earlier transaction's data beats are stalled.
- R11: When a transaction is waiting in the address slot with its tenure passed, its first beat comes in the cycle right after the earlier transaction's acknowledged last beat, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_wide | input | 1 | Bus width strap: 1 = 64-bit, 0 = 32-bit |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Address slot free, request accepted this cycle |
| req_addr | input | 32 | Request byte address |
| req_size | input | 4 | Byte count 1..8 (ignored for bursts) |
| req_burst | input | 1 | Full-line burst |
| req_write | input | 1 | 1 = write, 0 = read |
| at_valid | output | 1 | Address tenure in progress |
| at_addr | output | 32 | Address of the tenure |
| at_write | output | 1 | Write flag of the tenure |
| at_burst | output | 1 | Burst flag of the tenure |
| addr_retry | input | 1 | Slave retries the current address tenure |
| beat_valid | output | 1 | Data beat present |
| beat_addr | output | 32 | Address of the current beat |
| beat_lanes | output | 8 | Byte-lane enables of the current beat |
| beat_last | output | 1 | Current beat is the final one |
| beat_write | output | 1 | Write flag of the current beat |
| data_ack | input | 1 | Slave acknowledges the current beat |

## Verification
Two functions can fall in the same cycle. One is an address tenure for a new request. The other is a data beat of the previous request, which may be stalled or may be finishing. The bench provokes this by holding `data_ack` low on a burst and issuing a second request once the slot frees. It then checks that the second tenure shows up while the first beat holds, and that the slot refuses a third request. It then releases the acknowledge and checks that the waiting transaction's first beat follows the burst's last beat in the next cycle. A retried tenure is also judged against a free data stage, to show that the retry alone keeps the data stage idle.

// File: rtl/beat_seq_pkg.sv
package beat_seq_pkg;
  localparam int ADDR_W       = 32;
  localparam int LINE_BYTES   = 32;
  localparam int WIDE_BYTES   = 8;
  localparam int NARROW_BYTES = WIDE_BYTES / 2;
  localparam int WIDE_SH      = $clog2(WIDE_BYTES);
  localparam int NARROW_SH    = $clog2(NARROW_BYTES);
  localparam int CNT_W        = $clog2(LINE_BYTES / NARROW_BYTES) + 1;
  localparam int SIZE_W       = $clog2(WIDE_BYTES) + 1;
  localparam int LANE_W       = WIDE_BYTES;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [SIZE_W-1:0] size;
    logic              burst;
    logic              write;
    logic              wide;
    logic [CNT_W-1:0]  nbeats;
  } txn_t;

  // Number of data beats for a transaction on the given bus width.
  function automatic logic [CNT_W-1:0] beat_count(input logic wide,
                                                  input logic burst,
                                                  input logic [SIZE_W-1:0] size);
    if (burst)
      return wide ? CNT_W'(LINE_BYTES / WIDE_BYTES) : CNT_W'(LINE_BYTES / NARROW_BYTES);
    if (!wide && (size > SIZE_W'(NARROW_BYTES)))
      return CNT_W'(WIDE_BYTES / NARROW_BYTES);
    return CNT_W'(1);
  endfunction
endpackage

// File: rtl/beat_seq_mode.sv
module beat_seq_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic strap,
  output logic wide,
  output logic settled
);
  logic init_q, init_d;
  logic wide_q, wide_d;

  always_comb begin
    init_d = init_q;
    wide_d = wide_q;
    if (init_q) begin
      init_d = 1'b0;
      wide_d = strap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q <= 1'b1;
      wide_q <= 1'b1;
    end else begin
      init_q <= init_d;
      wide_q <= wide_d;
    end
  end

  assign wide    = wide_q;
  assign settled = !init_q;
endmodule

// File: rtl/beat_seq_aslot.sv
module beat_seq_aslot
  import beat_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  txn_t load_txn,
  input  logic retry,
  input  logic ds_free,
  output logic busy,
  output logic tenure,
  output logic hand,
  output txn_t txn
);
  logic v_q, v_d;
  logic done_q, done_d;
  txn_t txn_q, txn_d;
  logic passed;

  always_comb begin
    tenure = v_q && !done_q;
    passed = done_q || (tenure && !retry);
    hand   = v_q && passed && ds_free;

    v_d    = v_q;
    done_d = done_q;
    txn_d  = txn_q;
    if (hand) begin
      v_d    = 1'b0;
      done_d = 1'b0;
    end else if (tenure && !retry) begin
      done_d = 1'b1;
    end
    if (load) begin
      v_d    = 1'b1;
      done_d = 1'b0;
      txn_d  = load_txn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      v_q    <= v_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) txn_q <= txn_d;
  end

  assign busy = v_q;
  assign txn  = txn_q;
endmodule

// File: rtl/beat_seq_dstage.sv
module beat_seq_dstage
  import beat_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  txn_t              load_txn,
  input  logic              ack,
  output logic              valid,
  output logic              free,
  output logic [ADDR_W-1:0] addr,
  output logic [LANE_W-1:0] lanes,
  output logic              last,
  output logic              write
);
  localparam int ONES_W = 2 * LANE_W;

  logic v_q, v_d;
  txn_t t_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  int unsigned       sh;
  logic [ADDR_W-1:0] span_mask, idx_w;
  logic [LANE_W-1:0] full_lanes;
  logic [ONES_W-1:0] ones;
  logic [ADDR_W-1:0] lane_off;
  logic              multi;

  always_comb begin
    last = v_q && (cnt_q == (t_q.nbeats - CNT_W'(1)));
    free = !v_q || (ack && last);

    v_d   = v_q;
    cnt_d = cnt_q;
    if (v_q && ack) begin
      if (last) v_d = 1'b0;
      else      cnt_d = cnt_q + CNT_W'(1);
    end
    if (load) begin
      v_d   = 1'b1;
      cnt_d = '0;
    end
  end

  // Beat address: wrap inside the aligned span of the whole transfer.
  always_comb begin
    sh        = t_q.wide ? WIDE_SH : NARROW_SH;
    multi     = t_q.burst || (t_q.nbeats != CNT_W'(1));
    span_mask = (ADDR_W'(t_q.nbeats) << sh) - ADDR_W'(1);
    idx_w     = ((t_q.addr >> sh) + ADDR_W'(cnt_q)) & (ADDR_W'(t_q.nbeats) - ADDR_W'(1));
    addr      = multi ? ((t_q.addr & ~span_mask) | (idx_w << sh)) : t_q.addr;
  end

  // Byte lanes: full bus for multi-beat, contiguous run otherwise.
  always_comb begin
    full_lanes = t_q.wide ? {LANE_W{1'b1}} : LANE_W'({NARROW_BYTES{1'b1}});
    ones       = (ONES_W'(1) << t_q.size) - ONES_W'(1);
    lane_off   = t_q.addr & ((ADDR_W'(1) << sh) - ADDR_W'(1));
    lanes      = multi ? full_lanes : (LANE_W'(ones << lane_off) & full_lanes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      cnt_q <= '0;
    end else begin
      v_q   <= v_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load) t_q <= load_txn;
  end

  assign valid = v_q;
  assign write = t_q.write;
endmodule

// File: rtl/beat_seq.sv
module beat_seq
  import beat_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_wide,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SIZE_W-1:0] req_size,
  input  logic              req_burst,
  input  logic              req_write,
  output logic              at_valid,
  output logic [ADDR_W-1:0] at_addr,
  output logic              at_write,
  output logic              at_burst,
  input  logic              addr_retry,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [LANE_W-1:0] beat_lanes,
  output logic              beat_last,
  output logic              beat_write,
  input  logic              data_ack
);
  logic wide, settled;
  logic slot_busy, hand, ds_free, accept;
  txn_t in_txn, slot_txn;

  beat_seq_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap   (strap_wide),
    .wide    (wide),
    .settled (settled)
  );

  always_comb begin
    in_txn.addr   = req_addr;
    in_txn.size   = req_size;
    in_txn.burst  = req_burst;
    in_txn.write  = req_write;
    in_txn.wide   = wide;
    in_txn.nbeats = beat_count(wide, req_burst, req_size);
  end

  assign req_ready = settled && !slot_busy;
  assign accept    = req_valid && req_ready;

  beat_seq_aslot u_aslot (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_txn (in_txn),
    .retry    (addr_retry),
    .ds_free  (ds_free),
    .busy     (slot_busy),
    .tenure   (at_valid),
    .hand     (hand),
    .txn      (slot_txn)
  );

  assign at_addr  = slot_txn.addr;
  assign at_write = slot_txn.write;
  assign at_burst = slot_txn.burst;

  beat_seq_dstage u_dstage (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (hand),
    .load_txn (slot_txn),
    .ack      (data_ack),
    .valid    (beat_valid),
    .free     (ds_free),
    .addr     (beat_addr),
    .lanes    (beat_lanes),
    .last     (beat_last),
    .write    (beat_write)
  );
endmodule

// File: rtl/beat_seq_chk.sv
module beat_seq_chk
  import beat_seq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              at_valid,
  input logic [ADDR_W-1:0] at_addr,
  input logic              addr_retry,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [LANE_W-1:0] beat_lanes,
  input logic              beat_last,
  input logic              data_ack
);
  AST_RETRY_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
    at_valid && addr_retry |=> at_valid && $stable(at_addr)); // R9

  AST_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !data_ack |=> beat_valid && $stable(beat_addr) && $stable(beat_lanes) && $stable(beat_last)); // R7

  AST_SLOT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    at_valid |-> !req_ready); // R10

  AST_ACCEPT_TENURE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> at_valid); // R10

  AST_LANES_SET: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_lanes != '0); // R6
endmodule

bind beat_seq beat_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .at_valid   (at_valid),
  .at_addr    (at_addr),
  .addr_retry (addr_retry),
  .beat_valid (beat_valid),
  .beat_addr  (beat_addr),
  .beat_lanes (beat_lanes),
  .beat_last  (beat_last),
  .data_ack   (data_ack)
);

// File: tb/sim_beat_seq.sv
`timescale 1ns/1ps
module sim_beat_seq;
  logic        clk, rst_n, strap_wide;
  logic        req_valid, req_ready, req_burst, req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_size;
  logic        at_valid, at_write, at_burst, addr_retry;
  logic [31:0] at_addr;
  logic        beat_valid, beat_last, beat_write, data_ack;
  logic [31:0] beat_addr;
  logic [7:0]  beat_lanes;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic cur_wide;

  beat_seq u0 (
    .clk(clk), .rst_n(rst_n), .strap_wide(strap_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_burst(req_burst), .req_write(req_write),
    .at_valid(at_valid), .at_addr(at_addr), .at_write(at_write), .at_burst(at_burst),
    .addr_retry(addr_retry), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_lanes(beat_lanes), .beat_last(beat_last), .beat_write(beat_write),
    .data_ack(data_ack)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic        wide;
    logic [31:0] addr;
    logic [3:0]  size;
    logic        burst;
    logic        write;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h0000_1003, 4'd1, 1'b0, 1'b0},
    '{1'b1, 32'h0000_2000, 4'd8, 1'b0, 1'b1},
    '{1'b1, 32'h0000_2004, 4'd4, 1'b0, 1'b0},
    '{1'b1, 32'h0000_3010, 4'd8, 1'b1, 1'b0},
    '{1'b1, 32'h0000_3000, 4'd8, 1'b1, 1'b1},
    '{1'b0, 32'h0000_4006, 4'd2, 1'b0, 1'b0},
    '{1'b0, 32'h0000_4004, 4'd4, 1'b0, 1'b1},
    '{1'b0, 32'h0000_5008, 4'd8, 1'b0, 1'b0},
    '{1'b0, 32'h0000_6014, 4'd4, 1'b1, 1'b0},
    '{1'b0, 32'h0000_6000, 4'd4, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_beats(input logic w, input logic b, input logic [3:0] s);
    if (b) return w ? 4 : 8;
    if (!w && s == 4'd8) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] exp_addr(input logic w, input logic [31:0] a, input int n, input int k);
    int step, span, idx;
    if (n == 1) return a;
    step = w ? 8 : 4;
    span = n * step;
    idx  = (int'(a) % span) / step;
    return (a - (a % span)) + 32'(((idx + k) % n) * step);
  endfunction

  function automatic logic [7:0] exp_lanes(input logic w, input logic [31:0] a, input logic [3:0] s, input int n);
    logic [15:0] run;
    if (n > 1) return w ? 8'hFF : 8'h0F;
    run = (16'(1) << s) - 16'(1);
    if (w) return 8'(run << a[2:0]);
    return 8'(run << a[1:0]) & 8'h0F;
  endfunction

  task automatic finish_up;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", 64'(cyc), 64'd100000);
      finish_up();
    end
  end

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic w);
    rst_n = 1'b0; strap_wide = w; req_valid = 1'b0; addr_retry = 1'b0; data_ack = 1'b0;
    req_addr = '0; req_size = 4'd1; req_burst = 1'b0; req_write = 1'b0;
    step(); step();
    chk(!req_ready && !at_valid && !beat_valid, "R1 idle in reset",
        64'({req_ready, at_valid, beat_valid}), 64'd0);
    rst_n = 1'b1;
    chk(!req_ready, "R2 not ready before first edge", 64'(req_ready), 64'd0);
    step();
    chk(req_ready, "R2 ready after mode capture", 64'(req_ready), 64'd1);
    cur_wide = w;
  endtask

  task automatic issue(input logic [31:0] a, input logic [3:0] s, input logic b, input logic wr);
    req_valid = 1'b1; req_addr = a; req_size = s; req_burst = b; req_write = wr;
    step();
    req_valid = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int n;
    n = exp_beats(v.wide, v.burst, v.size);
    data_ack = 1'b1;
    issue(v.addr, v.size, v.burst, v.write);
    chk(at_valid && at_addr == v.addr, "R10 tenure after accept", 64'(at_addr), 64'(v.addr));
    step();
    for (int k = 0; k < n; k++) begin
      chk(beat_valid, v.wide ? "R3 beat present" : "R4 beat present", 64'(beat_valid), 64'd1);
      chk(beat_addr == exp_addr(v.wide, v.addr, n, k), "R5 beat address",
          64'(beat_addr), 64'(exp_addr(v.wide, v.addr, n, k)));
      chk(beat_lanes == exp_lanes(v.wide, v.addr, v.size, n), "R6 byte lanes",
          64'(beat_lanes), 64'(exp_lanes(v.wide, v.addr, v.size, n)));
      chk(beat_last == (k == n - 1) && beat_write == v.write, "R8 last and write flags",
          64'({beat_last, beat_write}), 64'({(k == n - 1), v.write}));
      step();
    end
    chk(!beat_valid, v.wide ? "R3 beat count" : "R4 beat count", 64'(beat_valid), 64'd0);
    data_ack = 1'b0;
  endtask

  initial begin
    cur_wide = 1'b0;
    do_reset(1'b1);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wide != cur_wide) do_reset(VECS[i].wide);
      run_vec(VECS[i]);
    end

    // R7: stalled burst holds each beat until acknowledged
    do_reset(1'b1);
    data_ack = 1'b0;
    issue(32'h100, 4'd8, 1'b1, 1'b0);
    step();
    for (int k = 0; k < 3; k++) begin
      chk(beat_valid && beat_addr == 32'h100 && !beat_last, "R7 hold without ack",
          64'(beat_addr), 64'h100);
      step();
    end
    data_ack = 1'b1;
    step();
    chk(beat_addr == 32'h108, "R7 advance on ack", 64'(beat_addr), 64'h108);
    step();
    step();
    chk(beat_addr == 32'h118 && beat_last, "R8 final beat flagged", 64'(beat_addr), 64'h118);
    step();
    data_ack = 1'b0;

    // R9: retried tenure repeats and makes no beat
    data_ack = 1'b1;
    issue(32'h200, 4'd8, 1'b0, 1'b1);
    addr_retry = 1'b1;
    step();
    addr_retry = 1'b0;
    chk(at_valid && at_addr == 32'h200, "R9 tenure repeated", 64'(at_addr), 64'h200);
    chk(!beat_valid, "R9 no beat from retried tenure", 64'(beat_valid), 64'd0);
    step();
    chk(beat_valid && beat_addr == 32'h200 && beat_last, "R9 beat after clean tenure",
        64'(beat_addr), 64'h200);
    step();
    data_ack = 1'b0;

    // R10/R11: tenure overlaps a stalled burst, then no gap between transactions
    issue(32'h400, 4'd8, 1'b1, 1'b0);
    step();
    chk(beat_valid && beat_addr == 32'h400 && req_ready, "R10 slot free during data",
        64'({beat_valid, req_ready}), 64'h3);
    issue(32'h504, 4'd4, 1'b0, 1'b0);
    chk(at_valid && at_addr == 32'h504 && beat_valid && beat_addr == 32'h400,
        "R10 tenure overlaps stalled beat", 64'(at_addr), 64'h504);
    chk(!req_ready, "R10 slot full", 64'(req_ready), 64'd0);
    step();
    chk(!at_valid && !req_ready, "R10 passed tenure waits", 64'({at_valid, req_ready}), 64'd0);
    data_ack = 1'b1;
    step();
    step();
    step();
    chk(beat_addr == 32'h418 && beat_last, "R8 last of first burst", 64'(beat_addr), 64'h418);
    step();
    chk(beat_valid && beat_addr == 32'h504 && beat_lanes == 8'hF0 && beat_last,
        "R11 next beat without gap", 64'(beat_addr), 64'h504);
    step();
    chk(!beat_valid, "R11 pipeline drained", 64'(beat_valid), 64'd0);
    data_ack = 1'b0;

    finish_up();
  end
endmodule